// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block produces the active-low select for one external memory bank behind a 32-bit bus master. Software sets it up through a small register port: a 16-bit base register and a combined mask/control register. On every bus access the unit compares the upper halfword of the address with the base. Any bit flagged in the address mask is treated as don't-care.

A matching access is then qualified. The bank must be marked valid, the access class must not be blocked, and a write must not fall on a write-protected bank. When all of this holds, the unit drives its registered chip select low. If a write is refused only because of write protection, the unit raises a one-cycle error flag instead of selecting the device.

Top module: `csd_chipsel`

## Requirements
- R1: A register write at offset 0x0C loads the base register from write-data bits 15..0. Reading offset 0x0C returns the base zero-extended to 32 bits.
- R2: A register write at offset 0x10 loads the control fields. The fields are: valid at bit 0, five class-block bits at bits 5..1, write-protect at bit 8, and the address mask at bits 31..16. Reading offset 0x10 returns these fields with every other bit as zero.
- R3: After reset, both registers read zero, `cs_n` is 1 and `prot_err` is 0.
- R4: `cs_n` is registered. It is 0 in the cycle after a clock edge at which `bus_strobe` was high with a qualified hit. It is 1 in the cycle after an edge at which `bus_strobe` was low.
- R5: An address matches when, for each i in 0..15, `bus_addr[16+i]` equals base bit i or mask bit i is 1. For example, base 0x2000 with mask 0x0001 covers 0x2000_0000 through 0x2001_FFFF.
- R6: While the valid bit is 0, `cs_n` never goes low, whatever the address.
- R7: `bus_type` carries a one-hot access class. Bit 0 is supervisor code, bit 1 supervisor data, bit 2 user code, bit 3 user data, and bit 4 reserved. An access whose class bit k is set while control bit k+1 is 1 does not assert `cs_n`. When all block bits are 0, every class is allowed.
- R8: With write-protect at 1, a matching write leaves `cs_n` at 1, while a matching read still asserts it. With write-protect at 0, both reads and writes assert it.
- R9: `prot_err` is 1 for exactly one cycle, in the cycle after the first strobe cycle of a write that is refused only because of write protection. It stays 0 for the rest of that held strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_off | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` |
| bus_strobe | input | 1 | Bus access strobe |
| bus_addr | input | 32 | Bus address |
| bus_write | input | 1 | 1 for a write access |
| bus_type | input | 5 | One-hot access class |
| cs_n | output | 1 | Registered active-low chip select |
| prot_err | output | 1 | One-cycle write-protection error |

## Verification
The checker watches several rules on every cycle. The select stays high after an idle strobe, while the bank is invalid, after a blocked class, and after a write to a protected bank. It also checks that the error flag never coincides with a select and never lasts two cycles.

Only the bench scenarios can show the rest. These cover the exact window arithmetic of the masked compare and the register readback layout. They also cover the positive cases: a legitimate access really does pull the select low, and the error flag fires only on the first cycle of a held write.

// File: rtl/csd_pkg.sv
package csd_pkg;
    parameter int unsigned DW        = 32;
    parameter int unsigned HI_W      = 16;
    parameter int unsigned LO_W      = DW - HI_W;
    parameter int unsigned NTYPES    = 5;
    parameter int unsigned OFF_W     = 5;
    parameter int unsigned VALID_BIT = 0;
    parameter int unsigned BLK_LSB   = 1;
    parameter int unsigned WP_BIT    = 8;
    parameter int unsigned AMASK_LSB = DW - HI_W;
    parameter logic [OFF_W-1:0] BASE_OFF = 5'h0C;
    parameter logic [OFF_W-1:0] MASK_OFF = 5'h10;

    typedef struct packed {
        logic [HI_W-1:0]   base;
        logic [HI_W-1:0]   amask;
        logic              wp;
        logic [NTYPES-1:0] blk;
        logic              valid;
    } cfg_t;

    typedef struct packed {
        logic cs_n;
        logic prot_err;
        logic strb;
    } out_t;
endpackage

// File: rtl/csd_regs.sv
module csd_regs
    import csd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && reg_off == BASE_OFF) begin
            cfg_d.base = reg_wdata[HI_W-1:0];
        end
        if (reg_we && reg_off == MASK_OFF) begin
            cfg_d.amask = reg_wdata[DW-1:AMASK_LSB];
            cfg_d.wp    = reg_wdata[WP_BIT];
            cfg_d.blk   = reg_wdata[BLK_LSB +: NTYPES];
            cfg_d.valid = reg_wdata[VALID_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_off == BASE_OFF) begin
            reg_rdata[HI_W-1:0] = cfg_q.base;
        end else if (reg_off == MASK_OFF) begin
            reg_rdata[DW-1:AMASK_LSB]     = cfg_q.amask;
            reg_rdata[WP_BIT]             = cfg_q.wp;
            reg_rdata[BLK_LSB +: NTYPES]  = cfg_q.blk;
            reg_rdata[VALID_BIT]          = cfg_q.valid;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
(
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] base,
    input  logic [HI_W-1:0] amask,
    output logic            hit
);
    logic [HI_W-1:0] bit_ok;

    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        assign bit_ok[i] = amask[i] | ~(addr_hi[i] ^ base[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/csd_qual.sv
module csd_qual
    import csd_pkg::*;
(
    input  logic              strobe,
    input  logic              write,
    input  logic [NTYPES-1:0] typ,
    input  logic              addr_hit,
    input  cfg_t              cfg,
    output logic              grant,
    output logic              viol
);
    logic type_ok;
    logic pre_ok;

    assign type_ok = ~|(typ & cfg.blk);
    assign pre_ok  = strobe & cfg.valid & addr_hit & type_ok;
    assign viol    = pre_ok & write & cfg.wp;
    assign grant   = pre_ok & ~viol;
endmodule

// File: rtl/csd_chipsel.sv
module csd_chipsel
    import csd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              bus_strobe,
    input  logic [DW-1:0]     bus_addr,
    input  logic              bus_write,
    input  logic [NTYPES-1:0] bus_type,
    output logic              cs_n,
    output logic              prot_err
);
    cfg_t cfg;
    logic addr_hit;
    logic grant;
    logic viol;
    logic addr_lo_unused;

    logic              cfg_valid;
    logic              cfg_wp;
    logic [NTYPES-1:0] cfg_blk;

    out_t st_d, st_q;

    assign addr_lo_unused = ^bus_addr[LO_W-1:0];

    csd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    csd_match u_match (
        .addr_hi (bus_addr[DW-1:LO_W]),
        .base    (cfg.base),
        .amask   (cfg.amask),
        .hit     (addr_hit)
    );

    csd_qual u_qual (
        .strobe   (bus_strobe),
        .write    (bus_write),
        .typ      (bus_type),
        .addr_hit (addr_hit),
        .cfg      (cfg),
        .grant    (grant),
        .viol     (viol)
    );

    assign cfg_valid = cfg.valid;
    assign cfg_wp    = cfg.wp;
    assign cfg_blk   = cfg.blk;

    always_comb begin
        st_d          = st_q;
        st_d.strb     = bus_strobe;
        st_d.cs_n     = ~grant;
        st_d.prot_err = viol & ~st_q.strb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_n     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n     = st_q.cs_n;
    assign prot_err = st_q.prot_err;
endmodule

// File: rtl/csd_chipsel_chk.sv
module csd_chipsel_chk
    import csd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_strobe,
    input logic              bus_write,
    input logic [NTYPES-1:0] bus_type,
    input logic              cs_n,
    input logic              prot_err,
    input logic              cfg_valid,
    input logic              cfg_wp,
    input logic [NTYPES-1:0] cfg_blk
);
    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> cs_n);

    // R6
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> cs_n);

    // R7
    class_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bus_type & cfg_blk)) |=> cs_n);

    // R8
    wp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && cfg_wp) |=> cs_n);

    // R9
    err_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> cs_n);

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> !prot_err);
endmodule

bind csd_chipsel csd_chipsel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_strobe (bus_strobe),
    .bus_write  (bus_write),
    .bus_type   (bus_type),
    .cs_n       (cs_n),
    .prot_err   (prot_err),
    .cfg_valid  (cfg_valid),
    .cfg_wp     (cfg_wp),
    .cfg_blk    (cfg_blk)
);

// File: tb/test_csd_chipsel.sv
module test_csd_chipsel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_strobe = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_type = 5'b00001;
    logic        cs_n;
    logic        prot_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csd_chipsel i_csd_chipsel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_strobe(bus_strobe),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_type(bus_type),
        .cs_n(cs_n), .prot_err(prot_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] off, input logic [31:0] exp);
        @(negedge clk);
        reg_off = off;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // One access, strobe held for 'hold' cycles, then released
    task automatic acc(input string req, input logic [31:0] a, input logic w,
                       input logic [4:0] t, input int hold,
                       input logic exp_sel, input logic exp_err);
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = a; bus_write = w; bus_type = t;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk({req, " cs_n"}, {31'b0, cs_n}, {31'b0, ~exp_sel});
            chk({req, " prot_err"}, {31'b0, prot_err}, {31'b0, (k == 0) ? exp_err : 1'b0});
        end
        bus_strobe = 1'b0;
        @(negedge clk);
        chk({req, " release"}, {30'b0, cs_n, prot_err}, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R3 reset state
        chk("R3 cs_n", {31'b0, cs_n}, 32'h1);
        chk("R3 prot_err", {31'b0, prot_err}, 32'h0);
        rd("R3 base", 5'h0C, 32'h0);
        rd("R3 ctrl", 5'h10, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 cs_n after release", {31'b0, cs_n}, 32'h1);

        // R6 unconfigured bank: base 0 matches addr 0 but valid=0
        acc("R6 invalid", 32'h0000_1234, 1'b0, 5'b00001, 1, 1'b0, 1'b0);

        // R1 / R2 readback layout
        wr(5'h0C, 32'hFFFF_ABCD);
        rd("R1 base readback", 5'h0C, 32'h0000_ABCD);
        wr(5'h10, 32'hFFFF_FFFF);
        rd("R2 ctrl readback", 5'h10, 32'hFFFF_013F);
        rd("R2 other offset", 5'h04, 32'h0);

        // R6 valid=0 with full mask still silent
        wr(5'h10, 32'hFFFF_0000);
        acc("R6 invalid fullmask", 32'h1357_0000, 1'b0, 5'b00010, 1, 1'b0, 1'b0);

        // R5 window example: base 0x2000, mask bit16
        wr(5'h0C, 32'h0000_2000);
        wr(5'h10, 32'h0001_0001);
        for (int h = 16'h1FFC; h <= 16'h2004; h++) begin
            acc("R5 window", {h[15:0], 16'h0010}, 1'b0, 5'b00001, 1,
                (h == 16'h2000) || (h == 16'h2001), 1'b0);
        end
        acc("R5 top edge", 32'h2001_FFFF, 1'b1, 5'b01000, 1, 1'b1, 1'b0);
        acc("R5 above", 32'h2002_0000, 1'b0, 5'b01000, 1, 1'b0, 1'b0);
        acc("R5 below", 32'h1FFF_FFFF, 1'b0, 5'b01000, 1, 1'b0, 1'b0);

        // R4 held read strobe keeps select low
        acc("R4 held", 32'h2000_0040, 1'b0, 5'b00100, 3, 1'b1, 1'b0);

        // R5 sweep: mask nibble x base nibble x addr nibble
        for (int m = 0; m < 16; m++) begin
            wr(5'h10, {12'h0, m[3:0], 16'h0001});
            for (int b = 0; b < 16; b++) begin
                wr(5'h0C, {16'h0, 12'h5A5, b[3:0]});
                for (int a = 0; a < 16; a++) begin
                    acc("R5 sweep", {12'h5A5, a[3:0], 16'h0}, 1'b0, 5'b00001, 1,
                        ((a[3:0] ^ b[3:0]) & ~m[3:0]) == 4'h0, 1'b0);
                end
            end
        end
        // R5 upper-bit mismatch with mask only on low bits
        acc("R5 upper mismatch", 32'hDA5F_0000, 1'b0, 5'b00001, 1, 1'b0, 1'b0);

        // R7 class blocking sweep
        wr(5'h0C, 32'h0000_2000);
        for (int blk = 0; blk < 32; blk++) begin
            wr(5'h10, {16'h0, 7'h0, 1'b0, 2'b0, blk[4:0], 1'b1});
            for (int t = 0; t < 5; t++) begin
                acc("R7 class", 32'h2000_0100, t[0], 5'(1 << t), 1, ~blk[t], 1'b0);
            end
        end

        // R8 / R9 write protection
        wr(5'h10, 32'h0000_0101);
        acc("R8 wp read", 32'h2000_0200, 1'b0, 5'b00010, 1, 1'b1, 1'b0);
        acc("R9 wp write", 32'h2000_0200, 1'b1, 5'b00010, 1, 1'b0, 1'b1);
        acc("R9 wp write held", 32'h2000_0200, 1'b1, 5'b00010, 3, 1'b0, 1'b1);
        acc("R9 wp write miss", 32'h3000_0200, 1'b1, 5'b00010, 1, 1'b0, 1'b0);
        wr(5'h10, 32'h0000_0103);
        acc("R9 wp blocked class", 32'h2000_0200, 1'b1, 5'b00001, 1, 1'b0, 1'b0);
        wr(5'h10, 32'h0000_0001);
        acc("R8 no wp write", 32'h2000_0200, 1'b1, 5'b00010, 1, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule